// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit collects event pulses from the port control lines and the two timers of a parallel interface adapter. It keeps one sticky flag per source and a mask of enabled sources, and it drives an active-low interrupt request whenever an enabled source has a flag pending. Software on the 8-bit register bus clears flags in two ways. It can write ones to the flag register. It can also touch a port or timer register, and that access clears the matching flag as a side effect.

Register accesses arrive as a one-cycle strobe with a read/write qualifier, a 4-bit register select and write data. The port, timer and control-line units decode their own modes. They hand this block single-cycle set pulses. The flag and enable values are presented on read-back ports so the bus multiplexer can return them.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset every flag and every enable is 0, `flag_rd` reads 0x00, `enable_rd` reads 0x80 and `irq_n` is 1.
- R2: A one-cycle set pulse raises its flag from the next clock edge. The bit positions are: port-A control 2 = bit 0, port-A control 1 = bit 1, port-B control 2 = bit 3, port-B control 1 = bit 4, timer 2 = bit 5, timer 1 = bit 6.
- R3: A write to select 13 clears each flag whose data bit is 1 and leaves flags with data bit 0 unchanged. Data bit 7 is ignored.
- R4: A write to select 14 with data bit 7 = 1 sets each enable whose data bit is 1. With data bit 7 = 0, it clears each enable whose data bit is 1. Writing 0x7F disables every source.
- R5: Bit 7 of `enable_rd` always reads 1.
- R6: Bit 7 of `flag_rd` is 1 exactly when some flag and its enable are both 1. `irq_n` is low in exactly those cycles.
- R7: Any access (read or write) to select 1 clears the port-A control-1 flag. An access to select 15 leaves that flag unchanged.
- R8: Any access to select 0 clears the port-B control-1 flag.
- R9: A write to select 5 or a read of select 4 clears the timer 1 flag. A read of select 5 or a write of select 4 leaves it unchanged.
- R10: A write to select 9 or a read of select 8 clears the timer 2 flag. A read of select 9 leaves it unchanged.
- R11: When a set pulse and a clear of the same flag occur in the same cycle, the flag ends up set.
- R12: With `acc_valid` low, the select, data and direction inputs change no state.
- R13: Flag bit 2 has no source and always reads 0, even when enable bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read for the current access |
| acc_sel | input | 4 | Register select of the access |
| acc_wdata | input | 8 | Write data of the access |
| set_a_ctl2 | input | 1 | Port-A control 2 event pulse |
| set_a_ctl1 | input | 1 | Port-A control 1 event pulse |
| set_b_ctl2 | input | 1 | Port-B control 2 event pulse |
| set_b_ctl1 | input | 1 | Port-B control 1 event pulse |
| set_tmr2 | input | 1 | Timer 2 event pulse |
| set_tmr1 | input | 1 | Timer 1 event pulse |
| flag_rd | output | 8 | Flag register read value, bit 7 = pending summary |
| enable_rd | output | 8 | Enable register read value, bit 7 = 1 |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The hardest case to reach is a collision: a source fires in the very cycle that software clears the same flag. The clear can come from a flag-register write or from a timer access. The stimulus table holds rows that raise the timer pulse together with the clearing access. The bench then checks that the flag survives and that the request stays asserted. Other rows pair a clearing select with its non-clearing sibling, such as a read of 5 against a write of 5, or select 15 against select 1. This shows that only the exact combination of direction and select removes a flag.

// File: rtl/irqfu_pkg.sv
package irqfu_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;
  localparam int FLAG_W = DATA_W - 1;

  // flag bit positions (read by software, so fixed)
  localparam int FB_A_CTL2 = 0;
  localparam int FB_A_CTL1 = 1;
  localparam int FB_RSVD   = 2;
  localparam int FB_B_CTL2 = 3;
  localparam int FB_B_CTL1 = 4;
  localparam int FB_TMR2   = 5;
  localparam int FB_TMR1   = 6;

  // bits that own a flip-flop
  localparam logic [FLAG_W-1:0] SRC_MASK = 7'b111_1011;

  // register selects that carry a side effect
  localparam int SEL_PORT_B  = 0;
  localparam int SEL_PORT_A  = 1;
  localparam int SEL_T1_LO   = 4;
  localparam int SEL_T1_HI   = 5;
  localparam int SEL_T2_LO   = 8;
  localparam int SEL_T2_HI   = 9;
  localparam int SEL_FLAG    = 13;
  localparam int SEL_ENABLE  = 14;
  localparam int SEL_PORT_AQ = 15;
endpackage

// File: rtl/irqfu_acc_decode.sv
module irqfu_acc_decode
  import irqfu_pkg::*;
#(
  parameter int SEL_W_P  = SEL_W,
  parameter int DATA_W_P = DATA_W,
  parameter int FLAG_W_P = DATA_W_P - 1
) (
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [SEL_W_P-1:0]  acc_sel,
  input  logic [DATA_W_P-1:0] acc_wdata,
  output logic [FLAG_W_P-1:0] clr_mask,
  output logic                en_wr,
  output logic                en_set,
  output logic [FLAG_W_P-1:0] en_mask
);
  logic is_rd, is_wr;
  logic hit_pb, hit_pa, hit_t1lo, hit_t1hi, hit_t2lo, hit_t2hi, hit_flag, hit_en;

  always_comb begin
    is_rd    = acc_valid & ~acc_write;
    is_wr    = acc_valid &  acc_write;
    hit_pb   = (acc_sel == SEL_W_P'(SEL_PORT_B));
    hit_pa   = (acc_sel == SEL_W_P'(SEL_PORT_A));
    hit_t1lo = (acc_sel == SEL_W_P'(SEL_T1_LO));
    hit_t1hi = (acc_sel == SEL_W_P'(SEL_T1_HI));
    hit_t2lo = (acc_sel == SEL_W_P'(SEL_T2_LO));
    hit_t2hi = (acc_sel == SEL_W_P'(SEL_T2_HI));
    hit_flag = (acc_sel == SEL_W_P'(SEL_FLAG));
    hit_en   = (acc_sel == SEL_W_P'(SEL_ENABLE));
  end

  always_comb begin
    clr_mask = '0;
    if (is_wr && hit_flag) clr_mask = acc_wdata[FLAG_W_P-1:0];
    if (acc_valid && hit_pa) clr_mask[FB_A_CTL1] = 1'b1;
    if (acc_valid && hit_pb) clr_mask[FB_B_CTL1] = 1'b1;
    if ((is_wr && hit_t1hi) || (is_rd && hit_t1lo)) clr_mask[FB_TMR1] = 1'b1;
    if ((is_wr && hit_t2hi) || (is_rd && hit_t2lo)) clr_mask[FB_TMR2] = 1'b1;
  end

  always_comb begin
    en_wr   = is_wr & hit_en;
    en_set  = acc_wdata[DATA_W_P-1];
    en_mask = acc_wdata[FLAG_W_P-1:0];
  end
endmodule

// File: rtl/irqfu_flag_bank.sv
module irqfu_flag_bank #(
  parameter int                 FLAG_W_P = 7,
  parameter logic [FLAG_W_P-1:0] SRC_MASK_P = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FLAG_W_P-1:0] set_vec,
  input  logic [FLAG_W_P-1:0] clr_vec,
  output logic [FLAG_W_P-1:0] flag_q,
  output logic [FLAG_W_P-1:0] flag_nxt
);
  for (genvar i = 0; i < FLAG_W_P; i++) begin : g_bit
    if (SRC_MASK_P[i]) begin : g_src
      logic bit_q, bit_d;
      // a pulse outranks any clear arriving in the same cycle
      always_comb bit_d = set_vec[i] | (bit_q & ~clr_vec[i]);
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= bit_d;
      end
      assign flag_q[i]   = bit_q;
      assign flag_nxt[i] = bit_d;
    end else begin : g_rsvd
      logic unused_in;
      assign unused_in   = set_vec[i] ^ clr_vec[i];
      assign flag_q[i]   = 1'b0;
      assign flag_nxt[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqfu_enable_reg.sv
module irqfu_enable_reg #(
  parameter int FLAG_W_P = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_wr,
  input  logic                en_set,
  input  logic [FLAG_W_P-1:0] en_mask,
  output logic [FLAG_W_P-1:0] en_q,
  output logic [FLAG_W_P-1:0] en_nxt
);
  always_comb begin
    en_nxt = en_q;
    if (en_wr) begin
      if (en_set) en_nxt = en_q | en_mask;
      else        en_nxt = en_q & ~en_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irqfu_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int SEL_W_P  = SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [SEL_W_P-1:0]  acc_sel,
  input  logic [DATA_W_P-1:0] acc_wdata,
  input  logic                set_a_ctl2,
  input  logic                set_a_ctl1,
  input  logic                set_b_ctl2,
  input  logic                set_b_ctl1,
  input  logic                set_tmr2,
  input  logic                set_tmr1,
  output logic [DATA_W_P-1:0] flag_rd,
  output logic [DATA_W_P-1:0] enable_rd,
  output logic                irq_n
);
  localparam int FW = DATA_W_P - 1;

  logic [FW-1:0] set_vec, clr_mask, en_mask;
  logic [FW-1:0] flag_q, flag_nxt, en_q, en_nxt;
  logic          en_wr, en_set, irq_n_q;

  always_comb begin
    set_vec            = '0;
    set_vec[FB_A_CTL2] = set_a_ctl2;
    set_vec[FB_A_CTL1] = set_a_ctl1;
    set_vec[FB_B_CTL2] = set_b_ctl2;
    set_vec[FB_B_CTL1] = set_b_ctl1;
    set_vec[FB_TMR2]   = set_tmr2;
    set_vec[FB_TMR1]   = set_tmr1;
  end

  irqfu_acc_decode #(
    .SEL_W_P(SEL_W_P), .DATA_W_P(DATA_W_P), .FLAG_W_P(FW)
  ) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .clr_mask(clr_mask), .en_wr(en_wr),
    .en_set(en_set), .en_mask(en_mask)
  );

  irqfu_flag_bank #(.FLAG_W_P(FW), .SRC_MASK_P(SRC_MASK[FW-1:0])) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_mask),
    .flag_q(flag_q), .flag_nxt(flag_nxt)
  );

  irqfu_enable_reg #(.FLAG_W_P(FW)) u_en (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_set(en_set),
    .en_mask(en_mask), .en_q(en_q), .en_nxt(en_nxt)
  );

  // request flop fed from next-state so it lines up with the flag flops
  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(flag_nxt & en_nxt);
  end

  always_comb begin
    flag_rd   = {|(flag_q & en_q), flag_q};
    enable_rd = {1'b1, en_q};
    irq_n     = irq_n_q;
  end
endmodule

// File: rtl/irqfu_checker.sv
module irqfu_checker (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [3:0] acc_sel,
  input logic [7:0] acc_wdata,
  input logic       set_a_ctl2,
  input logic       set_a_ctl1,
  input logic       set_b_ctl2,
  input logic       set_b_ctl1,
  input logic       set_tmr2,
  input logic       set_tmr1,
  input logic [7:0] flag_rd,
  input logic [7:0] enable_rd,
  input logic       irq_n
);
  logic wr_flag, wr_en;
  assign wr_flag = acc_valid && acc_write && acc_sel == 4'd13;
  assign wr_en   = acc_valid && acc_write && acc_sel == 4'd14;

  p_set_tmr1_r2: assert property (@(posedge clk) disable iff (rst)
    set_tmr1 |=> flag_rd[6]);
  p_set_b1_r2: assert property (@(posedge clk) disable iff (rst)
    set_b_ctl1 |=> flag_rd[4]);
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && acc_wdata[0] && !set_a_ctl2) |=> !flag_rd[0]);
  p_en_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc_wdata[7] && acc_wdata[6]) |=> enable_rd[6]);
  p_en_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !acc_wdata[7] && acc_wdata[6]) |=> !enable_rd[6]);
  p_en_top_r5: assert property (@(posedge clk) disable iff (rst)
    enable_rd[7]);
  p_irq_match_r6: assert property (@(posedge clk) disable iff (rst)
    irq_n == !flag_rd[7]);
  p_pa_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_sel == 4'd1 && !set_a_ctl1) |=> !flag_rd[1]);
  p_pb_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_sel == 4'd0 && !set_b_ctl1) |=> !flag_rd[4]);
  p_t1_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_sel == 4'd5 && !set_tmr1) |=> !flag_rd[6]);
  p_t2_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_sel == 4'd8 && !set_tmr2) |=> !flag_rd[5]);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (set_tmr2 && acc_valid && acc_write && acc_sel == 4'd9) |=> flag_rd[5]);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !set_a_ctl2 && !set_a_ctl1 && !set_b_ctl2 && !set_b_ctl1
     && !set_tmr2 && !set_tmr1) |=> ($stable(flag_rd) && $stable(enable_rd)));
  p_rsvd_zero_r13: assert property (@(posedge clk) disable iff (rst)
    !flag_rd[2]);
endmodule

bind irq_flag_unit irqfu_checker u_chk (.*);

// File: tb/irq_flag_unit_bench.sv
module irq_flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0] acc_sel = '0;
  logic [7:0] acc_wdata = '0;
  logic       set_a_ctl2 = 0, set_a_ctl1 = 0, set_b_ctl2 = 0;
  logic       set_b_ctl1 = 0, set_tmr2 = 0, set_tmr1 = 0;
  logic [7:0] flag_rd, enable_rd;
  logic       irq_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_flag_unit u_irq_flag_unit (.*);

  // row: req, valid, write, sel, wdata, events{t1,t2,b1,b2,-,a1,a2}, exp flag, exp enable, exp irq_n
  localparam int N = 28;
  localparam logic [41:0] TBL [N] = '{
    {4'd2,  1'b0,1'b0,4'd0, 8'h00,7'h01, 8'h01,8'h80,1'b1}, // R2 a2 -> bit0
    {4'd4,  1'b1,1'b1,4'd14,8'h83,7'h00, 8'h81,8'h83,1'b0}, // R4 set en 0,1
    {4'd2,  1'b0,1'b0,4'd0, 8'h00,7'h02, 8'h83,8'h83,1'b0}, // R2 a1 -> bit1
    {4'd7,  1'b1,1'b0,4'd15,8'h00,7'h00, 8'h83,8'h83,1'b0}, // R7 sel15 keeps
    {4'd7,  1'b1,1'b0,4'd1, 8'h00,7'h00, 8'h81,8'h83,1'b0}, // R7 sel1 clears
    {4'd3,  1'b1,1'b1,4'd13,8'h01,7'h00, 8'h00,8'h83,1'b1}, // R3
    {4'd2,  1'b0,1'b0,4'd0, 8'h00,7'h18, 8'h18,8'h83,1'b1}, // R2 b2,b1 masked
    {4'd4,  1'b1,1'b1,4'd14,8'h98,7'h00, 8'h98,8'h9B,1'b0}, // R4
    {4'd8,  1'b1,1'b0,4'd0, 8'h00,7'h00, 8'h88,8'h9B,1'b0}, // R8
    {4'd3,  1'b1,1'b1,4'd13,8'h10,7'h00, 8'h88,8'h9B,1'b0}, // R3 zero bits keep
    {4'd4,  1'b1,1'b1,4'd14,8'h08,7'h00, 8'h08,8'h93,1'b1}, // R4 clear en3
    {4'd2,  1'b0,1'b0,4'd0, 8'h00,7'h60, 8'h68,8'h93,1'b1}, // R2 timers
    {4'd6,  1'b1,1'b1,4'd14,8'hE0,7'h00, 8'hE8,8'hF3,1'b0}, // R6
    {4'd9,  1'b1,1'b1,4'd4, 8'h55,7'h00, 8'hE8,8'hF3,1'b0}, // R9 write 4 keeps
    {4'd9,  1'b1,1'b0,4'd5, 8'h00,7'h00, 8'hE8,8'hF3,1'b0}, // R9 read 5 keeps
    {4'd9,  1'b1,1'b1,4'd5, 8'h00,7'h00, 8'hA8,8'hF3,1'b0}, // R9 write 5 clears
    {4'd10, 1'b1,1'b0,4'd9, 8'h00,7'h00, 8'hA8,8'hF3,1'b0}, // R10 read 9 keeps
    {4'd10, 1'b1,1'b0,4'd8, 8'h00,7'h00, 8'h08,8'hF3,1'b1}, // R10 read 8 clears
    {4'd11, 1'b1,1'b1,4'd9, 8'h00,7'h20, 8'hA8,8'hF3,1'b0}, // R11 set wins
    {4'd10, 1'b1,1'b1,4'd9, 8'h00,7'h00, 8'h08,8'hF3,1'b1}, // R10 write 9 clears
    {4'd11, 1'b1,1'b1,4'd13,8'h40,7'h40, 8'hC8,8'hF3,1'b0}, // R11 set wins
    {4'd4,  1'b1,1'b1,4'd14,8'h7F,7'h00, 8'h48,8'h80,1'b1}, // R4 0x7F
    {4'd3,  1'b1,1'b1,4'd13,8'h7F,7'h00, 8'h00,8'h80,1'b1}, // R3
    {4'd13, 1'b1,1'b1,4'd14,8'h84,7'h00, 8'h00,8'h84,1'b1}, // R13 bit2 stays 0
    {4'd2,  1'b0,1'b0,4'd0, 8'h00,7'h02, 8'h02,8'h84,1'b1}, // R2
    {4'd12, 1'b0,1'b1,4'd13,8'h02,7'h00, 8'h02,8'h84,1'b1}, // R12 no strobe
    {4'd6,  1'b1,1'b1,4'd14,8'h82,7'h00, 8'h82,8'h86,1'b0}, // R6
    {4'd3,  1'b1,1'b1,4'd13,8'hFF,7'h00, 8'h00,8'h86,1'b1}  // R3 bit7 ignored
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_sel = '0; acc_wdata = '0;
    {set_tmr1, set_tmr2, set_b_ctl1, set_b_ctl2, set_a_ctl1, set_a_ctl2} = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", flag_rd, 8'h00, "flag_rd");
    check("R1", enable_rd, 8'h80, "enable_rd");
    check("R1", {7'd0, irq_n}, 8'h01, "irq_n");

    for (int i = 0; i < N; i++) begin
      string tag;
      tag = $sformatf("R%0d step%0d", TBL[i][41:38], i);
      acc_valid = TBL[i][37];
      acc_write = TBL[i][36];
      acc_sel   = TBL[i][35:32];
      acc_wdata = TBL[i][31:24];
      {set_tmr1, set_tmr2, set_b_ctl1, set_b_ctl2} = TBL[i][23:20];
      {set_a_ctl1, set_a_ctl2} = TBL[i][18:17];
      @(negedge clk);
      idle();
      check(tag, flag_rd, TBL[i][16:9], "flag_rd");
      check(tag, enable_rd, TBL[i][8:1], "enable_rd");
      check(tag, {7'd0, irq_n}, {7'd0, TBL[i][0]}, "irq_n");
    end

    // R1: reset in the middle of activity returns to the idle state
    set_tmr1 = 1;
    @(negedge clk); idle();
    acc_valid = 1; acc_write = 1; acc_sel = 4'd14; acc_wdata = 8'hC0;
    @(negedge clk); idle();
    check("R6 pre-reset", {7'd0, irq_n}, 8'h00, "irq_n");
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 mid-run", flag_rd, 8'h00, "flag_rd");
    check("R1 mid-run", enable_rd, 8'h80, "enable_rd");
    check("R1 mid-run", {7'd0, irq_n}, 8'h01, "irq_n");
    finished = 1;
    finish_run();
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule